// File: doc/BRIEF.md
# Burst Controller for a WAIT-Handshaking Pseudo-Static RAM

This block sits on the host side of a clocked parallel bus to a 16-bit pseudo-static RAM and runs burst reads and writes for a single user port. The user presents a start address, a word count, a direction, a latency-mode bit, and, for writes, one data word and byte mask per beat. The controller drives chip enable, address valid, write enable, output enable, the two byte-lane enables and the address. It decides from the device WAIT output, or from its own latency count, in which cycles a data word actually moves. The device is assumed to share the controller's clock.

In variable-latency mode no beat moves while WAIT is high. This covers the normal initial latency, any extra cycles caused by a collision with an internal refresh, and any stall in the middle of a burst. In fixed-latency mode WAIT is ignored. The first beat moves a set number of clocks after the address cycle, and one beat moves on every cycle after that. In both modes the controller cuts a request into separate bursts at every row boundary and opens the next row with a fresh address cycle. A watchdog on WAIT abandons a burst that stalls for too long and raises a sticky error flag.

Top module: `psram_burst_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the flag stays low until the request has completed or been abandoned.
- R2: Every burst opens with an address cycle in which `mem_adv_n` is low for exactly one clock, `mem_ce_n` is low and `mem_addr` holds the burst's first word address. `mem_ce_n` is high in the cycle before. From then until `mem_ce_n` rises, `mem_addr` does not change.
- R3: With `cfg_fixed_lat`=0 (latched at request acceptance), a data beat moves in exactly those data-phase cycles where `mem_wait` is low. This holds however long WAIT stays high, including extended latency and stalls mid-burst.
- R4: With `cfg_fixed_lat`=1, `mem_wait` is ignored. The first beat moves in the FIXED_LAT-th cycle after the address cycle, and one beat moves on each following cycle of the burst.
- R5: `mem_ce_n` stays low without a break from the address cycle until the burst's first beat has moved. The only exception is an abandoned burst (R11).
- R6: No burst crosses a boundary of ROW_WORDS words. A request that spans rows is issued as one burst per row touched, in address order, with `mem_ce_n` high for at least one cycle between bursts.
- R7: During a read burst, `mem_lb_n` and `mem_ub_n` are low and `mem_oe_n` is low for the data phase.
- R8: During a write, `wr_mask` bit 0 enables the low byte (data bits 7:0, pin `mem_lb_n`) and bit 1 enables the high byte (bits 15:8, pin `mem_ub_n`) for that beat. A disabled lane is held high, so the stored byte keeps its old value. Both lanes are high in write cycles where no beat moves.
- R9: `wr_ready` is high exactly in the cycles where a write beat moves. `wr_data` and `wr_mask` are consumed in those cycles, and a request sees exactly its word count of `wr_ready` cycles.
- R10: Each read beat returns its word on `rd_data` with `rd_valid` high one cycle after the beat, in address order. `rd_last` is high only with the final word of the request.
- R11: If `mem_wait` holds a variable-latency data phase for TIMEOUT_LIM consecutive cycles, the burst is abandoned at the edge ending the TIMEOUT_LIM-th such cycle, `mem_ce_n` goes high and `timeout_err` is set. The flag stays set until the next request is accepted, which clears it.
- R12: After reset, all six control pins are high, `req_ready` is high, and `wr_ready`, `rd_valid` and `timeout_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fixed_lat | input | 1 | 1 = count fixed latency, 0 = follow WAIT; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | First word address |
| req_len | input | LEN_W | Number of words, 1 or more |
| req_write | input | 1 | 1 = write, 0 = read |
| wr_data | input | 16 | Write word for the current beat |
| wr_mask | input | 2 | Byte enables for the current beat, bit 0 = low byte |
| wr_ready | output | 1 | Write beat moves this cycle |
| rd_data | output | 16 | Returned read word |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_last | output | 1 | Final word of the request |
| timeout_err | output | 1 | Last burst abandoned on a WAIT timeout |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_addr | output | ADDR_W | Device word address |
| mem_dq_out | output | 16 | Data driven to the device |
| mem_dq_oe | output | 1 | Drive `mem_dq_out` onto the bus |
| mem_dq_in | input | 16 | Data from the device |
| mem_wait | input | 1 | Device WAIT, high = no transfer |

## Verification
The bound checker enforces the pin discipline on every cycle. It checks the one-clock address strobe with the enable high before it, the frozen address, the lane enables during reads, and that no variable-latency beat moves while WAIT is high and every WAIT-low data cycle moves one. It also checks that no beat leaves the row its burst opened in, that chip enable does not rise before a first beat except on abandonment, and that returned data follows a read beat. Only the bench's device model and scoreboard can show that the right words reach the right addresses. This covers the fixed-latency beat schedule, byte masks leaving stored bytes untouched, the burst count and start address of each split request, and the exact cycle at which a stalled burst is dropped and the flag cleared again.

// File: rtl/psram_burst_pkg.sv
package psram_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } burst_state_e;

  // Words from addr up to and including the last word of its row (row_words is a power of two).
  function automatic int unsigned room_in_row(input int unsigned addr, input int unsigned row_words);
    return row_words - (addr & (row_words - 1));
  endfunction

  // Length of the burst that starts at addr with 'left' words still owed.
  function automatic int unsigned seg_words(input int unsigned addr, input int unsigned left,
                                            input int unsigned row_words);
    int unsigned room;
    room = room_in_row(addr, row_words);
    return (left < room) ? left : room;
  endfunction

endpackage

// File: rtl/psram_seg_plan.sv
module psram_seg_plan
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int LEN_W     = 8,
  parameter int ROW_WORDS = 128
) (
  input  logic [ADDR_W-1:0] seg_addr,
  input  logic [LEN_W-1:0]  words_left,
  output logic [LEN_W-1:0]  seg_len
);
  always_comb begin
    seg_len = LEN_W'(seg_words(32'(seg_addr), 32'(words_left), 32'(ROW_WORDS)));
  end
endmodule

// File: rtl/psram_beat_gate.sv
module psram_beat_gate #(
  parameter int FIXED_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic fixed_mode,
  input  logic dev_wait,
  output logic go
);
  localparam int LAT_W = $clog2(FIXED_LAT + 1);
  localparam logic [LAT_W-1:0] LAT_LIM = LAT_W'(FIXED_LAT);

  logic [LAT_W-1:0] lat_cnt;
  logic             lat_done;

  // Counts data-phase cycles after the address cycle; saturates once the latency is met.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          lat_cnt <= '0;
    else if (start)                      lat_cnt <= LAT_W'(1);
    else if (active && lat_cnt < LAT_LIM) lat_cnt <= lat_cnt + 1'b1;
  end

  assign lat_done = (lat_cnt >= LAT_LIM);
  assign go       = active && (fixed_mode ? lat_done : !dev_wait);
endmodule

// File: rtl/psram_stall_timer.sv
module psram_stall_timer #(
  parameter int TIMEOUT_LIM = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stalled,
  output logic expire
);
  localparam int TO_W = $clog2(TIMEOUT_LIM);
  localparam logic [TO_W-1:0] LAST = TO_W'(TIMEOUT_LIM - 1);

  logic [TO_W-1:0] run;

  assign expire = stalled && (run == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 run <= '0;
    else if (!stalled || expire) run <= '0;
    else                        run <= run + 1'b1;
  end
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_burst_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int LEN_W       = 8,
  parameter int ROW_WORDS   = 128,
  parameter int FIXED_LAT   = 4,
  parameter int TIMEOUT_LIM = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fixed_lat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [15:0]       wr_data,
  input  logic [1:0]        wr_mask,
  output logic              wr_ready,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              rd_last,
  output logic              timeout_err,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in,
  input  logic              mem_wait
);
  burst_state_e      state;
  logic [ADDR_W-1:0] seg_addr;
  logic [ADDR_W-1:0] beat_addr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  seg_left;
  logic [LEN_W-1:0]  seg_len_w;
  logic              is_wr;
  logic              fixed_q;
  logic              got_beat;

  // Named internal events
  logic in_addr, in_data, on_bus, go, beat, stalled, expire, seg_end, req_end;

  assign in_addr = (state == ST_ADDR);
  assign in_data = (state == ST_DATA);
  assign on_bus  = in_addr || in_data;
  assign beat    = in_data && go;
  assign stalled = in_data && !fixed_q && mem_wait;
  assign seg_end = beat && (seg_left == LEN_W'(1));
  assign req_end = beat && (remain == LEN_W'(1));

  psram_seg_plan #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_WORDS(ROW_WORDS)) u_plan (
    .seg_addr  (seg_addr),
    .words_left(remain),
    .seg_len   (seg_len_w)
  );

  psram_beat_gate #(.FIXED_LAT(FIXED_LAT)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (in_addr),
    .active    (in_data),
    .fixed_mode(fixed_q),
    .dev_wait  (mem_wait),
    .go        (go)
  );

  psram_stall_timer #(.TIMEOUT_LIM(TIMEOUT_LIM)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .stalled(stalled),
    .expire (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      seg_addr    <= '0;
      beat_addr   <= '0;
      remain      <= '0;
      seg_left    <= '0;
      is_wr       <= 1'b0;
      fixed_q     <= 1'b0;
      got_beat    <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          seg_addr    <= req_addr;
          remain      <= req_len;
          is_wr       <= req_write;
          fixed_q     <= cfg_fixed_lat;
          timeout_err <= 1'b0;
          state       <= ST_ADDR;
        end
        ST_ADDR: begin
          beat_addr <= seg_addr;
          seg_left  <= seg_len_w;
          got_beat  <= 1'b0;
          state     <= ST_DATA;
        end
        ST_DATA: begin
          if (beat) begin
            beat_addr <= beat_addr + 1'b1;
            remain    <= remain - 1'b1;
            seg_left  <= seg_left - 1'b1;
            got_beat  <= 1'b1;
            if (req_end) begin
              state <= ST_IDLE;
            end else if (seg_end) begin
              seg_addr <= beat_addr + 1'b1;
              state    <= ST_GAP;
            end
          end else if (expire) begin
            timeout_err <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_GAP: state <= ST_ADDR;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= beat && !is_wr;
      rd_last  <= req_end && !is_wr;
      if (beat && !is_wr) rd_data <= mem_dq_in;
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign wr_ready   = beat && is_wr;
  assign mem_ce_n   = !on_bus;
  assign mem_adv_n  = !in_addr;
  assign mem_we_n   = !(on_bus && is_wr);
  assign mem_oe_n   = !(in_data && !is_wr);
  assign mem_lb_n   = !on_bus || (is_wr && !(beat && wr_mask[0]));
  assign mem_ub_n   = !on_bus || (is_wr && !(beat && wr_mask[1]));
  assign mem_addr   = seg_addr;
  assign mem_dq_out = wr_data;
  assign mem_dq_oe  = beat && is_wr;
endmodule

// File: rtl/psram_burst_chk.sv
module psram_burst_chk #(
  parameter int ADDR_W    = 22,
  parameter int ROW_WORDS = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_last,
  input logic              timeout_err,
  input logic              mem_ce_n,
  input logic              mem_adv_n,
  input logic              mem_we_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_wait,
  input logic              beat,
  input logic              in_data,
  input logic              fixed_q,
  input logic              got_beat,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [ADDR_W-1:0] seg_addr
);
  localparam int ROW_W = $clog2(ROW_WORDS);

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  assert_adv_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);

  assert_adv_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_ce_n && $past(mem_ce_n)));

  assert_addr_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && mem_adv_n) |-> $stable(mem_addr));

  assert_no_beat_on_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !fixed_q) |-> !mem_wait);

  assert_beat_when_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !fixed_q && !mem_wait) |-> beat);

  assert_ce_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> ($past(got_beat || beat) || timeout_err));

  assert_row_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> (beat_addr[ADDR_W-1:ROW_W] == seg_addr[ADDR_W-1:ROW_W]));

  assert_read_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && mem_we_n) |-> (!mem_lb_n && !mem_ub_n));

  assert_idle_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !mem_dq_oe) |-> (mem_lb_n && mem_ub_n));

  assert_wr_ready_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (mem_dq_oe && !mem_we_n && !mem_ce_n));

  assert_rd_follows_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(beat && mem_we_n));

  assert_last_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  assert_abort_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (mem_ce_n && req_ready));
endmodule

bind psram_burst_ctrl psram_burst_chk #(.ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_last(rd_last), .timeout_err(timeout_err),
  .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
  .mem_dq_oe(mem_dq_oe), .mem_wait(mem_wait), .beat(beat), .in_data(in_data),
  .fixed_q(fixed_q), .got_beat(got_beat), .beat_addr(beat_addr), .seg_addr(seg_addr)
);

// File: tb/psram_burst_ctrl_tb.sv
`timescale 1ns/1ps
module psram_burst_ctrl_tb;
  localparam int AW = 10, LW = 6, ROWW = 16, FLAT = 4, TLIM = 24;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_fixed_lat = 0, req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_mask = '0;
  logic req_ready, wr_ready, rd_valid, rd_last, timeout_err;
  logic [15:0] rd_data;
  logic mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_dq_out;
  logic [15:0] dq_r = '0;
  logic wait_r = 1'b0;

  psram_burst_ctrl #(.ADDR_W(AW), .LEN_W(LW), .ROW_WORDS(ROWW), .FIXED_LAT(FLAT),
                     .TIMEOUT_LIM(TLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_fixed_lat(cfg_fixed_lat), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
    .wr_data(wr_data), .wr_mask(wr_mask), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_last(rd_last), .timeout_err(timeout_err),
    .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_r), .mem_wait(wait_r)
  );

  logic [15:0] dev_mem [MEMN];
  logic [15:0] ref_mem [MEMN];
  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int count_segs(input int addr, input int len);
    int a = addr, l = len, n = 0, room, take;
    while (l > 0) begin
      room = ROWW - (a % ROWW);
      take = (l < room) ? l : room;
      a += take; l -= take; n++;
    end
    return n;
  endfunction

  // Device model state
  bit m_active = 0, m_wr = 0, m_fixed = 0, m_hold = 0;
  int m_k = 0, m_ptr = 0, m_beats = 0, m_lat = 2, n_adv = 0, m_next = 0, m_start = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0;
    end else if (!mem_ce_n && !mem_adv_n) begin
      chk(int'(mem_addr) == m_next, "R2 burst start address", int'(mem_addr), m_next);
      m_active = 1; m_k = 0; m_ptr = int'(mem_addr); m_start = m_ptr;
      m_wr = !mem_we_n; m_beats = 0; n_adv++;
      m_lat = 2 + int'($urandom % 3) + ((($urandom % 3) == 0) ? 3 : 0);
    end else if (!mem_ce_n && m_active) begin
      m_k++;
      if (m_fixed ? (m_k >= FLAT) : !wait_r) begin
        if (m_beats > 0 && (m_ptr % ROWW) == 0) chk(0, "R6 burst crossed a row", m_ptr, 0);
        if (int'(mem_addr) != m_start) chk(0, "R2 address moved", int'(mem_addr), m_start);
        if (m_wr) begin
          chk(mem_dq_oe == 1'b1, "R9 data driven on beat", int'(mem_dq_oe), 1);
          if (!mem_lb_n) dev_mem[m_ptr][7:0]  = mem_dq_out[7:0];
          if (!mem_ub_n) dev_mem[m_ptr][15:8] = mem_dq_out[15:8];
        end else begin
          chk(!mem_lb_n && !mem_ub_n && !mem_oe_n, "R7 read lanes/oe",
              int'({mem_lb_n, mem_ub_n, mem_oe_n}), 0);
        end
        m_ptr++; m_beats++;
      end
    end else if (mem_ce_n && m_active) begin
      if (!(m_beats > 0 || m_hold)) chk(0, "R5 enable raised before first beat", m_beats, 1);
      m_active = 0;
      m_next = m_ptr;
    end
  end

  always @(negedge clk) begin
    if (m_active && !mem_ce_n) begin
      if (m_fixed) wait_r <= (m_k + 1 < FLAT);
      else wait_r <= m_hold || (m_k + 1 < m_lat) || ((m_k + 1 > m_lat) && (($urandom % 4) == 0));
      dq_r <= dev_mem[m_ptr & (MEMN - 1)];
    end else begin
      wait_r <= 1'b0;
    end
  end

  task automatic do_req(input int addr, input int len, input bit wr, input bit fixed,
                        input bit hold, input int mmode, input string rtag);
    logic [15:0] wd [64];
    logic [1:0]  wm [64];
    int idx = 0, ridx = 0, cyc = 0, adv0;
    for (int i = 0; i < len; i++) begin
      wd[i] = 16'($urandom);
      wm[i] = (mmode < 0) ? 2'($urandom) : 2'(mmode);
    end
    m_fixed = fixed; m_hold = hold; m_next = addr; adv0 = n_adv;
    @(posedge clk); #1;
    req_valid = 1; req_addr = AW'(addr); req_len = LW'(len); req_write = wr;
    cfg_fixed_lat = fixed; wr_data = wd[0]; wr_mask = wm[0];
    #2;
    chk(req_ready == 1'b1, "R1 ready when idle", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 0;
    while (cyc < 3000) begin
      wr_data = wd[(idx < len) ? idx : 0];
      wr_mask = wm[(idx < len) ? idx : 0];
      #2;
      if (wr_ready) idx++;
      if (rd_valid) begin
        chk(rd_data == ref_mem[addr + ridx], rtag, int'(rd_data), int'(ref_mem[addr + ridx]));
        chk(rd_last == (ridx == len - 1), "R10 last flag", int'(rd_last), int'(ridx == len - 1));
        ridx++;
      end
      if (req_ready) break;
      cyc++;
      @(posedge clk); #1;
    end
    if (hold) begin
      chk(timeout_err == 1'b1, "R11 flag raised", int'(timeout_err), 1);
      chk(m_k == TLIM, "R11 abandon cycle", m_k, TLIM);
      chk(mem_ce_n == 1'b1, "R11 enable released", int'(mem_ce_n), 1);
      chk(ridx == 0, "R11 no data returned", ridx, 0);
    end else begin
      chk(timeout_err == 1'b0, "R11 flag clear", int'(timeout_err), 0);
      if (wr) chk(idx == len, "R9 write beats", idx, len);
      else    chk(ridx == len, "R1 busy until all words returned", ridx, len);
      chk(n_adv - adv0 == count_segs(addr, len), "R6 burst count", n_adv - adv0,
          count_segs(addr, len));
      if (wr)
        for (int i = 0; i < len; i++) begin
          if (wm[i][0]) ref_mem[addr + i][7:0]  = wd[i][7:0];
          if (wm[i][1]) ref_mem[addr + i][15:8] = wd[i][15:8];
        end
    end
    @(posedge clk); #1;
  endtask

  bit finished = 0;

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMN; i++) begin
      dev_mem[i] = 16'($urandom);
      ref_mem[i] = dev_mem[i];
    end
    repeat (4) @(posedge clk);
    #3;
    chk({mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n} == 6'b111111,
        "R12 pins idle in reset",
        int'({mem_ce_n, mem_adv_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}), 63);
    chk(req_ready && !wr_ready && !rd_valid && !timeout_err, "R12 flags in reset",
        int'({req_ready, wr_ready, rd_valid, timeout_err}), 8);
    rst_n = 1;
    repeat (2) @(posedge clk);

    // Row-spanning write, then read back in both latency modes
    do_req(ROWW - 3, 8, 1, 0, 0, 3, "R3 read data");
    do_req(ROWW - 3, 8, 0, 1, 0, 0, "R4 fixed read data");
    do_req(ROWW - 3, 8, 0, 0, 0, 0, "R3 variable read data");
    // Byte lanes: no lanes, low only, high only
    do_req(100, 5, 1, 0, 0, 0, "R8");
    do_req(100, 5, 0, 0, 0, 0, "R8 masked-off bytes unchanged");
    do_req(200, 3, 1, 1, 0, 1, "R8");
    do_req(200, 3, 0, 1, 0, 0, "R8 high byte kept");
    do_req(300, 3, 1, 0, 0, 2, "R8");
    do_req(300, 3, 0, 0, 0, 0, "R8 low byte kept");
    // Single word at a row end; long request over several rows
    do_req(ROWW * 5 - 1, 1, 0, 1, 0, 0, "R4 single word");
    do_req(ROWW * 7 + 9, 40, 1, 1, 0, -1, "R4");
    do_req(ROWW * 7 + 9, 40, 0, 0, 0, 0, "R3 multi-row read data");
    // WAIT held forever, then recovery
    do_req(500, 4, 0, 0, 1, 0, "R11");
    do_req(500, 4, 0, 0, 0, 0, "R11 read after abandon");

    for (int n = 0; n < 80; n++) begin
      int len, addr;
      bit wr, fx;
      len  = 1 + int'($urandom % 40);
      addr = int'($urandom % (MEMN - len));
      wr   = 1'($urandom);
      fx   = 1'($urandom);
      do_req(addr, len, wr, fx, 0, -1, fx ? "R4 random read" : "R3 random read");
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (200000) @(posedge clk);
      end
    join_any
    if (!finished) chk(0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule